// File: doc/BRIEF.md
# Latched Parallel-to-Serial Shift Register

This block turns a parallel word into a serial bit stream. It holds the word in a capture latch first, so the next word can be sampled while the previous one is still shifting out. A strobe on the latch-clock pin samples the parallel pins into the capture latch. A level-sensitive mode pin selects what the shift register does. When mode is low, the register keeps copying the latch. When mode is high, each shift-clock edge moves the register one place towards the output. Stage A (bit 0) takes the serial input. Stage H (the top bit) drives the serial output.

All logic runs on one system clock. The two strobe pins are external clock-like signals. Each one passes through a short synchronizer and a rising-edge detector, which produces a single-cycle internal strobe. Each strobe pin must stay high for at least two system clocks and low for at least two. There are two resets. A synchronous system reset initialises everything. An asynchronous active-low clear empties only the shift register and leaves the latch alone.

The word, the serial input and the serial output are plain levels sampled against external strobes. None of them carries a valid/ready handshake, so there is no back-pressure. A producer that is too fast simply overwrites the latch.

Top module: `latched_p2s`

## Requirements
- R1: While `sys_rst_n` is low at a clock edge, the latch, the shift register and the edge-detector state are cleared, so `ser_out` reads 0. A parallel load taken just after reset yields an all-zero word.
- R2: A rising edge on `latch_clk_in` copies `par_in` into the capture latch in every mode. With mode high, this capture leaves the shift register unchanged.
- R3: While `mode_shift` is 0, the shift register follows the capture latch on every clock, and shift-clock edges do not move it.
- R4: While `mode_shift` is 1, each rising edge on `shift_clk_in` moves stage n to stage n+1 and loads stage A (bit 0) from `ser_in`.
- R5: `ser_out` always equals stage H (bit WIDTH-1). `par_in[0]` maps to stage A and `par_in[WIDTH-1]` maps to stage H, so a loaded word leaves H first.
- R6: Driving `sr_clr_n` low clears the shift register and `ser_out` at once, without waiting for a clock edge. The capture latch keeps its contents.
- R7: `ser_in` has no effect while `mode_shift` is 0.
- R8: If a latch strobe occurs while `mode_shift` is 0, the new parallel word enters the latch and the shift register on the same clock.
- R9: If latch and shift strobes occur on the same clock while `mode_shift` is 1, the latch captures `par_in` and the register shifts normally.
- R10: While `mode_shift` is 1 and no shift strobe is present, the shift register holds its value.
- R11: A strobe pin held high for many clocks gives exactly one action, because only a rising edge acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Synchronous active-low system reset |
| sr_clr_n | input | 1 | Asynchronous active-low shift-register clear |
| latch_clk_in | input | 1 | Capture strobe; its rising edge samples `par_in` |
| shift_clk_in | input | 1 | Shift strobe; its rising edge shifts when mode is high |
| mode_shift | input | 1 | 1 = serial shift, 0 = load from latch |
| ser_in | input | 1 | Serial data entering stage A |
| par_in | input | WIDTH | Parallel word, bit 0 is stage A |
| ser_out | output | 1 | Stage H of the shift register |

## Verification
The bench builds the block with WIDTH = 8 and SYNC_STAGES = 2. Every pattern can therefore be shifted out in full, and the bench checks the H-first order bit by bit. The two-stage synchronizer sets how long the strobe pulses must last. The bench uses pulses three clocks high and five clocks low, which leaves room to check the cases where the latch and shift strobes land together, and a strobe held high that must act only once.

// File: rtl/latched_p2s_pkg.sv
package latched_p2s_pkg;

  // Action applied to the shift register in one system-clock cycle
  typedef enum logic [1:0] {
    SR_HOLD  = 2'd0,
    SR_LOAD  = 2'd1,
    SR_SHIFT = 2'd2
  } sr_op_e;

  // Strobe channel indices in the edge detector
  localparam int unsigned CH_LATCH = 0;
  localparam int unsigned CH_SHIFT = 1;
  localparam int unsigned N_CH     = 2;

endpackage

// File: rtl/p2s_edge_strobe.sv
module p2s_edge_strobe #(
  parameter int unsigned N_IN        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            sys_rst_n,
  input  logic [N_IN-1:0] raw_in,
  output logic [N_IN-1:0] rise_stb
);

  localparam int unsigned CHAIN = SYNC_STAGES + 1;

  for (genvar g = 0; g < N_IN; g++) begin : g_ch
    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk) begin
      if (!sys_rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[CHAIN-2:0], raw_in[g]};
      end
    end

    // Newest synchronized sample high, previous one low
    assign rise_stb[g] = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
  end

endmodule

// File: rtl/p2s_capture_latch.sv
module p2s_capture_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             sys_rst_n,
  input  logic             cap_stb,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] lat_q
);

  always_ff @(posedge clk) begin
    if (!sys_rst_n) begin
      lat_q <= '0;
    end else if (cap_stb) begin
      lat_q <= par_in;
    end
  end

endmodule

// File: rtl/p2s_shift_core.sv
module p2s_shift_core
  import latched_p2s_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             sys_rst_n,
  input  logic             sr_clr_n,
  input  sr_op_e           op,
  input  logic [WIDTH-1:0] load_word,
  input  logic             ser_in,
  output logic [WIDTH-1:0] sreg_q
);

  always_ff @(posedge clk or negedge sr_clr_n) begin
    if (!sr_clr_n) begin
      sreg_q <= '0;
    end else if (!sys_rst_n) begin
      sreg_q <= '0;
    end else begin
      unique case (op)
        SR_LOAD:  sreg_q <= load_word;
        SR_SHIFT: sreg_q <= {sreg_q[WIDTH-2:0], ser_in};
        default:  sreg_q <= sreg_q;
      endcase
    end
  end

endmodule

// File: rtl/latched_p2s.sv
module latched_p2s
  import latched_p2s_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             sys_rst_n,
  input  logic             sr_clr_n,
  input  logic             latch_clk_in,
  input  logic             shift_clk_in,
  input  logic             mode_shift,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out
);

  logic [N_CH-1:0]  stb;
  logic             cap_stb;
  logic             shf_stb;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] load_word;
  logic [WIDTH-1:0] sreg_q;
  sr_op_e           op;

  p2s_edge_strobe #(
    .N_IN        (N_CH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .raw_in    ({shift_clk_in, latch_clk_in}),
    .rise_stb  (stb)
  );

  assign cap_stb = stb[CH_LATCH];
  assign shf_stb = stb[CH_SHIFT];

  p2s_capture_latch #(.WIDTH(WIDTH)) u_latch (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .cap_stb   (cap_stb),
    .par_in    (par_in),
    .lat_q     (lat_q)
  );

  // Load mode passes a word being captured straight through
  assign load_word = cap_stb ? par_in : lat_q;

  always_comb begin
    if (!mode_shift)  op = SR_LOAD;
    else if (shf_stb) op = SR_SHIFT;
    else              op = SR_HOLD;
  end

  p2s_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .sr_clr_n  (sr_clr_n),
    .op        (op),
    .load_word (load_word),
    .ser_in    (ser_in),
    .sreg_q    (sreg_q)
  );

  assign ser_out = sreg_q[WIDTH-1];

endmodule

// File: rtl/latched_p2s_sva.sv
module latched_p2s_sva #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             sys_rst_n,
  input logic             sr_clr_n,
  input logic             mode_shift,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic             ser_out,
  input logic             cap_stb,
  input logic             shf_stb,
  input logic [WIDTH-1:0] lat_q,
  input logic [WIDTH-1:0] sreg_q
);

  p_capture_r2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    cap_stb |=> (lat_q == $past(par_in)));

  p_latch_keep_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !cap_stb |=> $stable(lat_q));

  p_level_load_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (sr_clr_n && !mode_shift && !cap_stb) |=> (!sr_clr_n || sreg_q == $past(lat_q)));

  p_shift_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (sr_clr_n && mode_shift && shf_stb) |=>
      (!sr_clr_n || sreg_q == {$past(sreg_q[WIDTH-2:0]), $past(ser_in)}));

  p_hold_r10: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (sr_clr_n && mode_shift && !shf_stb) |=> (!sr_clr_n || $stable(sreg_q)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !sr_clr_n |-> (ser_out == 1'b0));

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!sys_rst_n)
    shf_stb |=> !shf_stb);

endmodule

bind latched_p2s latched_p2s_sva #(.WIDTH(WIDTH)) u_sva (
  .clk        (clk),
  .sys_rst_n  (sys_rst_n),
  .sr_clr_n   (sr_clr_n),
  .mode_shift (mode_shift),
  .ser_in     (ser_in),
  .par_in     (par_in),
  .ser_out    (ser_out),
  .cap_stb    (cap_stb),
  .shf_stb    (shf_stb),
  .lat_q      (lat_q),
  .sreg_q     (sreg_q)
);

// File: tb/latched_p2s_tb.sv
module latched_p2s_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         sys_rst_n = 1'b0;
  logic         sr_clr_n = 1'b1;
  logic         latch_clk_in = 1'b0;
  logic         shift_clk_in = 1'b0;
  logic         mode_shift = 1'b1;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         ser_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [W-1:0] lat_m = '0;
  logic [W-1:0] sr_m  = '0;

  always #4 clk = ~clk;

  latched_p2s #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .sys_rst_n(sys_rst_n), .sr_clr_n(sr_clr_n),
    .latch_clk_in(latch_clk_in), .shift_clk_in(shift_clk_in),
    .mode_shift(mode_shift), .ser_in(ser_in), .par_in(par_in),
    .ser_out(ser_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ser_out=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Strobe pulse(s): three clocks high, five low
  task automatic pulse(input bit do_latch, input bit do_shift);
    @(negedge clk);
    latch_clk_in = do_latch;
    shift_clk_in = do_shift;
    idle(3);
    latch_clk_in = 1'b0;
    shift_clk_in = 1'b0;
    idle(5);
  endtask

  // Checks W bits leave H first, inserting ins[W-1] first
  task automatic shift_out(input string req, input logic [W-1:0] ins);
    for (int i = 0; i < W; i++) begin
      check(req, ser_out, sr_m[W-1]);
      ser_in = ins[W-1-i];
      pulse(1'b0, 1'b1);
      sr_m = {sr_m[W-2:0], ins[W-1-i]};
    end
    check(req, ser_out, sr_m[W-1]);
  endtask

  task automatic load_level();
    @(negedge clk);
    mode_shift = 1'b0;
    idle(2);
    sr_m = lat_m;
    mode_shift = 1'b1;
    idle(1);
  endtask

  task automatic t_reset();
    idle(3);
    check("R1 reset out", ser_out, 1'b0);
    sys_rst_n = 1'b1;
    idle(2);
    load_level();
    shift_out("R1 latch zero", 8'hA5);
  endtask

  task automatic t_capture_shift_mode();
    par_in = 8'h3C;
    pulse(1'b1, 1'b0);
    lat_m = 8'h3C;
    check("R2 no load in shift mode", ser_out, sr_m[W-1]);
    load_level();
    check("R5 H first after load", ser_out, 1'b0);
    shift_out("R2 R5 captured word", 8'h5A);
  endtask

  task automatic t_load_blocks_shift();
    @(negedge clk);
    mode_shift = 1'b0;
    sr_m = lat_m;
    for (int k = 0; k < 3; k++) begin
      ser_in = k[0];
      pulse(1'b0, 1'b1);
      check("R3 R7 shift blocked in load mode", ser_out, lat_m[W-1]);
    end
    mode_shift = 1'b1;
    idle(1);
    shift_out("R7 serial input ignored", 8'hC3);
  endtask

  task automatic t_load_through();
    @(negedge clk);
    mode_shift = 1'b0;
    par_in = 8'h96;
    pulse(1'b1, 1'b0);
    lat_m = 8'h96;
    sr_m = 8'h96;
    check("R8 new word reaches output", ser_out, 1'b1);
    mode_shift = 1'b1;
    idle(1);
    shift_out("R8 load-through word", 8'h00);
  endtask

  task automatic t_clear();
    @(negedge clk);
    mode_shift = 1'b0;
    par_in = 8'hF0;
    pulse(1'b1, 1'b0);
    lat_m = 8'hF0;
    sr_m = 8'hF0;
    mode_shift = 1'b1;
    ser_in = 1'b1;
    pulse(1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    sr_m = 8'hC3;
    check("R4 two shifts", ser_out, 1'b1);
    sr_clr_n = 1'b0;
    #1;
    check("R6 clear without clock", ser_out, 1'b0);
    sr_m = '0;
    idle(2);
    sr_clr_n = 1'b1;
    idle(1);
    shift_out("R6 register emptied", 8'h00);
    load_level();
    check("R6 latch survived clear", ser_out, 1'b1);
    shift_out("R6 latch word intact", 8'h6B);
  endtask

  task automatic t_simultaneous();
    ser_in = 1'b1;
    par_in = 8'h2D;
    pulse(1'b1, 1'b1);
    lat_m = 8'h2D;
    sr_m = {sr_m[W-2:0], 1'b1};
    shift_out("R9 shift with capture", 8'h00);
    load_level();
    shift_out("R9 capture with shift", 8'h00);
  endtask

  task automatic t_hold();
    load_level();
    for (int k = 0; k < 6; k++) begin
      ser_in = k[0];
      idle(1);
      check("R10 hold without strobe", ser_out, sr_m[W-1]);
    end
    shift_out("R10 held word", 8'h00);
  endtask

  task automatic t_held_strobe();
    load_level();
    @(negedge clk);
    ser_in = 1'b0;
    shift_clk_in = 1'b1;
    idle(10);
    shift_clk_in = 1'b0;
    idle(5);
    sr_m = {sr_m[W-2:0], 1'b0};
    shift_out("R11 single shift per edge", 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_capture_shift_mode();
    t_load_blocks_shift();
    t_load_through();
    t_clear();
    t_simultaneous();
    t_hold();
    t_held_strobe();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

endmodule